// File: doc/BRIEF.md
# Shared Non-Maskable Interrupt Router

This block gathers a set of interrupt request lines and drives one registered non-maskable interrupt output toward the CPU. Each routable source owns a 5-bit routing field. A source joins the non-maskable group only when its field holds all ones. The selected requests and a small set of dedicated error inputs are combined by an OR. The result reaches the output only while a global enable bit is set. Software sets that enable bit after a hard or soft reset. The sources are level-sensitive, and the block never latches an edge.

Several handlers can share the one output. Each handler clears its own source and then writes a self-clearing acknowledge bit. The acknowledge drops the output for a fixed number of cycles. If any selected source is still pending after that, the output rises again and the CPU sees a fresh edge. External lines are synchronized, and each one can be inverted so that active-low lines with pull-ups can be used. One internal line, the memory ECC error, is never allowed onto the output. Software configures the block through a simple write-only register port.

Top module: `nmi_router`

## Requirements
- R1: After the synchronous reset `rst` the output `nmi_o` is 0, the global enable and the software request bit are cleared, every routing field is 0 and every inversion bit is 0.
- R2: Register map, written when `wr_en` is 1. Address 0 is control: bit 0 is the global enable, bit 1 is the acknowledge, bit 2 is the software request. Address 1 is the inversion mask, with bit k for external line k. Address 2+k holds the routing field for source k in `wr_data[4:0]`. Source order is: external lines 0..N_EXT-1, then internal lines, then the software request as the last source. Only the value 5'b11111 selects a source; any other value excludes it.
- R3: `nmi_o` is the OR of all selected, active sources and the dedicated inputs, gated by the global enable. It follows an internal request or a register write after one clock edge.
- R4: `soft_rst` clears the global enable. From the second edge after it, `nmi_o` is 0 until software sets the enable again.
- R5: Each bit of `nmi_only_i` drives the output without any routing field, subject only to the global enable and the acknowledge hold.
- R6: The internal line at index ECC_IDX never affects `nmi_o`, even when its routing field holds 5'b11111.
- R7: An external line whose inversion bit is 1 counts as active when it is low.
- R8: A change on an external line reaches `nmi_o` at the third clock edge: two synchronizer stages, then the output register.
- R9: The block does not latch requests. When every selected source is released, `nmi_o` falls one edge after the change reaches the combining logic.
- R10: A write with control bit 1 set forces `nmi_o` to 0 for exactly DONE_LOW_CYCLES cycles, starting at the edge that takes the write. At the following edge the output rises again if a selected source is still pending.
- R11: The acknowledge bit is not stored. Once the hold ends, a still-pending source keeps `nmi_o` at 1 with no further write.
- R12: The software request bit, when routed through the last routing field, raises `nmi_o` while it is set and releases it when it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| soft_rst | input | 1 | Synchronous soft reset; clears the global enable |
| ext_req_i | input | N_EXT | Asynchronous external request lines |
| int_req_i | input | N_INT | Internal routable request lines |
| nmi_only_i | input | N_ONLY | Internal error lines that can only raise the non-maskable output |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| nmi_o | output | 1 | Registered non-maskable interrupt request to the CPU |

## Verification
Each result is due a fixed number of edges after its stimulus. Internal and dedicated inputs take one edge, and so do register writes after the edge that takes them. External lines take three edges. The acknowledge hold starts at the write's own edge and lasts DONE_LOW_CYCLES cycles. The soft reset shows on the output at the second edge after it. For each stimulus, the driver queues the expected output value together with the exact cycle it is due in. The monitor compares on the falling clock edge of that cycle and reports any entry it meets at a different cycle. The checks also sample the cycle just before an external change is due, so that a shorter or longer latency is caught.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  localparam int ROUTE_W          = 5;
  localparam logic [ROUTE_W-1:0] ROUTE_NMI = 5'b11111;
  localparam int ADDR_CTRL        = 0;
  localparam int ADDR_INV         = 1;
  localparam int ADDR_ROUTE_BASE  = 2;
  localparam int CTRL_EN_BIT      = 0;
  localparam int CTRL_DONE_BIT    = 1;
  localparam int CTRL_SW_BIT      = 2;
  typedef logic [ROUTE_W-1:0] route_t;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      q_o      <= '0;
    end else begin
      stage1_q <= d_i;
      q_o      <= stage1_q;
    end
  end
endmodule

// File: rtl/nmi_cfg_regs.sv
module nmi_cfg_regs
  import nmi_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int N_EXT  = 15,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            soft_rst,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  output logic                            en_q,
  output logic                            sw_q,
  output logic                            done_pulse,
  output logic [N_EXT-1:0]                inv_q,
  output logic [N_SRC-1:0][ROUTE_W-1:0]   route_q
);
  logic ctrl_wr, inv_wr;
  logic unused_hi_bits;

  assign ctrl_wr    = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
  assign inv_wr     = wr_en && (wr_addr == ADDR_W'(ADDR_INV));
  assign done_pulse = ctrl_wr && wr_data[CTRL_DONE_BIT];
  assign unused_hi_bits = ^wr_data[DATA_W-1:N_EXT];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      sw_q  <= 1'b0;
      inv_q <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q <= wr_data[CTRL_EN_BIT];
        sw_q <= wr_data[CTRL_SW_BIT];
      end
      if (soft_rst) en_q <= 1'b0;
      if (inv_wr) inv_q <= wr_data[N_EXT-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < N_SRC; i++) begin
        if (wr_addr == ADDR_W'(ADDR_ROUTE_BASE + i))
          route_q[i] <= wr_data[ROUTE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/nmi_route_gate.sv
module nmi_route_gate
  import nmi_pkg::*;
#(
  parameter int N_SRC   = 32,
  parameter int N_ONLY  = 2,
  parameter int ECC_POS = 15
) (
  input  logic [N_SRC-1:0]              req_i,
  input  logic [N_SRC-1:0][ROUTE_W-1:0] route_i,
  input  logic [N_ONLY-1:0]             nmi_only_i,
  output logic                          any_o
);
  logic [N_SRC-1:0] sel;

  for (genvar i = 0; i < N_SRC; i++) begin : g_sel
    if (i == ECC_POS) begin : g_blocked
      assign sel[i] = 1'b0;
    end else begin : g_open
      assign sel[i] = (route_i[i] == ROUTE_NMI);
    end
  end

  assign any_o = (|(req_i & sel)) | (|nmi_only_i);
endmodule

// File: rtl/nmi_router.sv
module nmi_router
  import nmi_pkg::*;
#(
  parameter int N_EXT           = 15,
  parameter int N_INT           = 16,
  parameter int N_ONLY          = 2,
  parameter int ECC_IDX         = 0,
  parameter int DONE_LOW_CYCLES = 4,
  parameter int ADDR_W          = 6,
  parameter int DATA_W          = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic [N_EXT-1:0]  ext_req_i,
  input  logic [N_INT-1:0]  int_req_i,
  input  logic [N_ONLY-1:0] nmi_only_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              nmi_o
);
  localparam int N_SRC   = N_EXT + N_INT + 1;
  localparam int ECC_POS = N_EXT + ECC_IDX;
  localparam int CNT_W   = $clog2(DONE_LOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(DONE_LOW_CYCLES - 1);
  localparam logic [N_SRC-1:0] ECC_MASK  = N_SRC'(1) << ECC_POS;

  logic                          en_q, sw_q, done_pulse, any_req, hold_active;
  logic [N_EXT-1:0]              inv_q, ext_sync;
  logic [N_SRC-1:0][ROUTE_W-1:0] route_q;
  logic [N_SRC-1:0]              req_vec;
  logic [CNT_W-1:0]              hold_cnt;

  nmi_sync #(.W(N_EXT)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (ext_req_i),
    .q_o (ext_sync)
  );

  nmi_cfg_regs #(
    .N_SRC (N_SRC),
    .N_EXT (N_EXT),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .en_q      (en_q),
    .sw_q      (sw_q),
    .done_pulse(done_pulse),
    .inv_q     (inv_q),
    .route_q   (route_q)
  );

  assign req_vec = {sw_q, int_req_i, ext_sync ^ inv_q};

  nmi_route_gate #(
    .N_SRC  (N_SRC),
    .N_ONLY (N_ONLY),
    .ECC_POS(ECC_POS)
  ) u_gate (
    .req_i     (req_vec),
    .route_i   (route_q),
    .nmi_only_i(nmi_only_i),
    .any_o     (any_req)
  );

  assign hold_active = (hold_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
      nmi_o    <= 1'b0;
    end else begin
      if (done_pulse)       hold_cnt <= HOLD_LOAD;
      else if (hold_active) hold_cnt <= hold_cnt - CNT_W'(1);
      nmi_o <= en_q && any_req && !hold_active && !done_pulse;
    end
  end

  // R3: a cleared global enable keeps the output low at the next edge
  a_r3_gated_off: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !nmi_o);

  // R10: the acknowledge write drops the output at its own edge
  a_r10_done_drop: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !nmi_o);

  // R10: the output stays low while the hold counter runs
  a_r10_hold_low: assert property (@(posedge clk) disable iff (rst)
    hold_active |=> !nmi_o);

  // R5: a dedicated error input raises the output with no routing field
  a_r5_nmi_only: assert property (@(posedge clk) disable iff (rst)
    (en_q && !hold_active && !done_pulse && (|nmi_only_i)) |=> nmi_o);

  // R6: the ECC line alone never raises the output
  a_r6_ecc_blocked: assert property (@(posedge clk) disable iff (rst)
    ((nmi_only_i == '0) && ((req_vec & ~ECC_MASK) == '0)) |=> !nmi_o);

  // R4: soft reset clears the output from the second edge on
  a_r4_soft_rst: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> ##1 !nmi_o);
endmodule

// File: tb/tb_nmi_router.sv
`timescale 1ns/1ps
module tb_nmi_router;
  localparam int N_EXT  = 15;
  localparam int N_INT  = 16;
  localparam int N_ONLY = 2;
  localparam int D      = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              soft_rst = 1'b0;
  logic [N_EXT-1:0]  ext_req_i = '0;
  logic [N_INT-1:0]  int_req_i = '0;
  logic [N_ONLY-1:0] nmi_only_i = '0;
  logic              wr_en = 1'b0;
  logic [5:0]        wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic              nmi_o;

  nmi_router #(.DONE_LOW_CYCLES(D)) dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .ext_req_i(ext_req_i), .int_req_i(int_req_i), .nmi_only_i(nmi_only_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .nmi_o(nmi_o)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int    due;
    logic  val;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare each queued expectation in its due cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      checks++;
      if (e.due != cyc) begin
        failures++;
        $display("FAIL %s: missed due cycle %0d (now %0d) actual=%b expected=%b",
                 e.tag, e.due, cyc, nmi_o, e.val);
      end else if (nmi_o !== e.val) begin
        failures++;
        $display("FAIL %s: cycle %0d actual=%b expected=%b", e.tag, cyc, nmi_o, e.val);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_at(int off, logic v, string tag);
    q.push_back('{cyc + off, v, tag});
  endtask

  task automatic wr(int a, int d);
    wr_addr = 6'(a);
    wr_data = 32'(d);
    wr_en   = 1'b1;
    tick(1);
    wr_en   = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    expect_at(0, 1'b0, "R1 reset output low");
    tick(2);

    // internal line 3 routed (address 2+15+3) while enable is off
    wr(20, 31);
    int_req_i[3] = 1'b1;
    expect_at(1, 1'b0, "R3 enable off blocks");
    tick(3);
    wr(0, 1);
    expect_at(1, 1'b1, "R3 enable on passes");
    tick(2);
    int_req_i[3] = 1'b0;
    expect_at(1, 1'b0, "R9 level release");
    tick(2);

    // routing field one bit short of all ones
    wr(21, 30);
    int_req_i[4] = 1'b1;
    expect_at(1, 1'b0, "R2 field 11110 excluded");
    tick(2);
    int_req_i[4] = 1'b0;

    // ECC line is internal index 0 -> source 15 -> address 17
    wr(17, 31);
    int_req_i[0] = 1'b1;
    expect_at(1, 1'b0, "R6 ECC never routed");
    tick(3);
    int_req_i[0] = 1'b0;

    nmi_only_i[1] = 1'b1;
    expect_at(1, 1'b1, "R5 dedicated input raises");
    tick(2);
    nmi_only_i[1] = 1'b0;
    expect_at(1, 1'b0, "R5 dedicated input released");
    tick(2);

    // external line 2 at address 4
    wr(4, 31);
    ext_req_i[2] = 1'b1;
    expect_at(2, 1'b0, "R8 not before third edge");
    expect_at(3, 1'b1, "R8 third edge");
    tick(4);
    wr(1, 1 << 2);
    expect_at(1, 1'b0, "R7 inverted high is idle");
    tick(2);
    ext_req_i[2] = 1'b0;
    expect_at(3, 1'b1, "R7 inverted low is active");
    tick(4);

    // acknowledge with the source still pending
    wr(0, 3);
    for (int k = 0; k < D; k++) expect_at(k, 1'b0, "R10 hold low");
    expect_at(D, 1'b1, "R10 re-assert after hold");
    expect_at(D + 3, 1'b1, "R11 acknowledge not stored");
    tick(D + 4);

    ext_req_i[2] = 1'b1;
    expect_at(3, 1'b0, "R9 external release");
    tick(4);
    wr(0, 3);
    expect_at(D, 1'b0, "R10 nothing pending stays low");
    tick(D + 2);

    // software request, routing address 2+31
    wr(33, 31);
    wr(0, 5);
    expect_at(1, 1'b1, "R12 software request");
    tick(2);
    wr(0, 1);
    expect_at(1, 1'b0, "R12 software clear");
    tick(2);

    int_req_i[3]  = 1'b1;
    nmi_only_i[0] = 1'b1;
    expect_at(1, 1'b1, "R3 two sources");
    tick(2);
    int_req_i[3] = 1'b0;
    expect_at(1, 1'b1, "R3 remaining source holds");
    tick(2);

    soft_rst = 1'b1;
    tick(1);
    soft_rst = 1'b0;
    expect_at(1, 1'b0, "R4 soft reset clears");
    expect_at(4, 1'b0, "R4 stays cleared");
    tick(5);
    wr(0, 1);
    expect_at(1, 1'b1, "R4 re-enable");
    tick(2);
    nmi_only_i[0] = 1'b0;
    expect_at(1, 1'b0, "R5 final release");
    tick(3);

    while (q.size() > 0) tick(1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule